// File: doc/BRIEF.md
# GPIO Controller with Edge and Level Interrupts

This block gives software control over a bank of general-purpose pins through a small memory-mapped bus of 32-bit words. Each pin can be driven from a register or handed to an alternate function. It can also be turned into an input whose level software can read. When the block drives a pin, its output value and output enable come from registers. When the pin is bypassed, the alternate function supplies both. The raw pad level is always passed on to the alternate function.

Every pin has its own interrupt detector. The detector first brings the pin level into the clock domain through two flops. It can then fire on a rising edge, a falling edge, both edges, a high level or a low level. Edge events are latched into a status bit that is cleared when status is read. A level-mode status bit follows the live pin condition. A mask register gates the status bits into a single interrupt line. Mask bits are changed only through two write-one command words: one unmasks pins and the other masks them.

Bus access is a single-cycle request of valid, write, address and data. A read returns its data one cycle later, together with a response strobe.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: With bypass bit 0, a pin's pad enable is 1 only when its direction bit is 0 (output) and its output-enable bit is 1, and the pad output equals the output-value bit. A direction bit of 1 makes the pin an input and never drives the pad.
- R2: With bypass bit 1, the pin's pad output and pad enable follow alt_out and alt_oe. alt_in always carries the raw pad input.
- R3: Byte offsets 0x00 bypass, 0x04 direction, 0x08 output enable, 0x0C output value, 0x24 trigger type, 0x28 trigger value and 0x2C any-edge read back what was last written. Offset 0x10 returns the pin levels after the two-flop synchroniser.
- R4: A read request returns its data on rsp_rdata with rsp_valid high in the next cycle only. Bits at or above NPINS read as 0, and offsets outside the map read as 0.
- R5: Writing 1s to offset 0x18 clears those mask bits (unmasks the pins). Writing 1s to offset 0x1C sets them. Zero bits leave the mask unchanged. The mask reads at offset 0x14.
- R6: After reset every register reads 0, except the mask, which reads with all implemented bits set. The interrupt line is low.
- R7: With trigger-type bit 0 and any-edge bit 0, a trigger-value bit of 1 latches status on a rising edge and a value of 0 latches status on a falling edge.
- R8: An any-edge bit of 1 latches status on both edges, whatever the type and value bits hold.
- R9: With type bit 1 and any-edge bit 0, the status bit equals the synchronised level when the value bit is 1 and its inverse when the value bit is 0. Reading status does not clear it.
- R10: Reading status (offset 0x20) clears the latched edge bits that were returned. An edge arriving in the same cycle stays latched.
- R11: irq is high exactly when some status bit is set whose mask bit is 0.
- R12: Writes to offsets 0x10, 0x14 and 0x20 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Pad output values |
| pin_oe | output | NPINS | Pad output enables |
| alt_out | input | NPINS | Alternate-function output values |
| alt_oe | input | NPINS | Alternate-function output enables |
| alt_in | output | NPINS | Pad levels to the alternate function |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with NPINS = 24 rather than the full 32. With that width, the zero upper byte of every register becomes visible, and so do the all-ones reset mask limited to the implemented pins and the ignored upper bits of all-ones writes. Every trigger mode is exercised on a distinct low pin. The clear-on-read of edge bits is checked against level bits that persist across repeated status reads. A change in the synchronised level is sampled only after the cycles that the two-flop synchroniser and the status flop take.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  output logic [NPINS-1:0]  alt_in,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_BYP  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_OEN  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_INP  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_UNM  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_SETM = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_TYP  = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_ANY  = ADDR_W'(8'h2C);

  logic [NPINS-1:0] byp_q, dir_q, oen_q, out_q, msk_q, typ_q, val_q, any_q;
  logic [NPINS-1:0] sync1_q, sync2_q, prev_q, sticky_q;
  logic [NPINS-1:0] wd, rise, fall, edge_mode, level_mode, edge_ev, level_hit, status;
  logic             wr, rd, rd_sts;
  logic [31:0]      rd_mux;

  assign wd  = req_wdata[NPINS-1:0];
  assign wr  = req_valid & req_write;
  assign rd  = req_valid & ~req_write;
  assign rd_sts = rd && (req_addr == A_STS);

  // pad muxing
  assign alt_in  = pin_in;
  assign pin_out = (byp_q & alt_out) | (~byp_q & out_q);
  assign pin_oe  = (byp_q & alt_oe)  | (~byp_q & ~dir_q & oen_q);

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= '0;
      dir_q <= '0;
      oen_q <= '0;
      out_q <= '0;
      typ_q <= '0;
      val_q <= '0;
      any_q <= '0;
      msk_q <= '1;
    end else if (wr) begin
      case (req_addr)
        A_BYP:  byp_q <= wd;
        A_DIR:  dir_q <= wd;
        A_OEN:  oen_q <= wd;
        A_OUT:  out_q <= wd;
        A_TYP:  typ_q <= wd;
        A_VAL:  val_q <= wd;
        A_ANY:  any_q <= wd;
        A_UNM:  msk_q <= msk_q & ~wd;
        A_SETM: msk_q <= msk_q | wd;
        default: ;
      endcase
    end
  end

  // synchroniser and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise       = sync2_q & ~prev_q;
  assign fall       = ~sync2_q & prev_q;
  assign level_mode = typ_q & ~any_q;
  assign edge_mode  = ~level_mode;
  assign edge_ev    = (any_q & (rise | fall))
                    | (~any_q & ~typ_q & ((val_q & rise) | (~val_q & fall)));
  assign level_hit  = level_mode & ~(sync2_q ^ val_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else sticky_q <= ((rd_sts ? '0 : sticky_q) | edge_ev) & edge_mode;
  end

  assign status = sticky_q | level_hit;
  assign irq    = |(status & ~msk_q);

  // read path
  always_comb begin
    rd_mux = '0;
    case (req_addr)
      A_BYP: rd_mux = 32'(byp_q);
      A_DIR: rd_mux = 32'(dir_q);
      A_OEN: rd_mux = 32'(oen_q);
      A_OUT: rd_mux = 32'(out_q);
      A_INP: rd_mux = 32'(sync2_q);
      A_MSK: rd_mux = 32'(msk_q);
      A_STS: rd_mux = 32'(status);
      A_TYP: rd_mux = 32'(typ_q);
      A_VAL: rd_mux = 32'(val_q);
      A_ANY: rd_mux = 32'(any_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rd_mux : '0;
    end
  end

  // assertions
  p_input_not_driven_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & dir_q & ~byp_q) == '0));

  p_unmask_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_UNM) |=> ((msk_q & $past(wd)) == '0));

  p_mask_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_SETM) |=> ((msk_q & $past(wd)) == $past(wd)));

  p_rsp_next_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);

  p_rsp_only_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);

  p_level_never_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sticky_q & level_mode) == '0));

  p_read_clears_old_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sts |=> ((sticky_q & ~$past(edge_ev)) == '0));

  p_all_masked_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (&msk_q) |-> !irq);

  p_ro_mask_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_MSK) |=> $stable(msk_q));

endmodule

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  localparam int NP = 24;
  localparam logic [31:0] IMPL = 32'h00FF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NP-1:0] pin_in = '0, alt_out = '0, alt_oe = '0;
  logic [NP-1:0] pin_out, pin_oe, alt_in;
  logic irq;

  int n_tests = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R6 irq after reset", {31'b0, irq}, 32'h0);
    check("R6 pin_oe after reset", 32'(pin_oe), 32'h0);
    for (int a = 0; a <= 8'h2C; a += 4) begin
      rd(8'(a), d);
      if (a == 8'h14) check("R6 mask reset all ones", d, IMPL);
      else check("R6 register reset zero", d, 32'h0);
    end
  endtask

  task automatic t_pads();
    wr(8'h08, 32'h0000_00F0);
    wr(8'h0C, 32'h0000_00A0);
    @(negedge clk);
    check("R1 pad enable from oe", 32'(pin_oe), 32'h0000_00F0);
    check("R1 pad out value", 32'(pin_out), 32'h0000_00A0);
    wr(8'h04, 32'h0000_0030);
    @(negedge clk);
    check("R1 input pins undriven", 32'(pin_oe), 32'h0000_00C0);
    alt_oe = '1; alt_out = '0;
    wr(8'h00, 32'h0000_0081);
    @(negedge clk);
    check("R2 bypass oe", 32'(pin_oe), 32'h0000_00C1);
    check("R2 bypass out", 32'(pin_out), 32'h0000_0020);
    pin_in = 24'h00_5A5A;
    #1;
    check("R2 alt_in raw", 32'(alt_in), 32'h0000_5A5A);
    pin_in = '0; alt_oe = '0;
    wr(8'h00, 0); wr(8'h04, 0); wr(8'h08, 0); wr(8'h0C, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    logic [7:0] addrs [7] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h24, 8'h28, 8'h2C};
    foreach (addrs[i]) begin
      wr(addrs[i], 32'hFFFF_FFFF);
      rd(addrs[i], d);
      check("R3 R4 readback upper zero", d, IMPL);
      wr(addrs[i], 32'h0000_1234);
      rd(addrs[i], d);
      check("R3 readback pattern", d, 32'h0000_1234);
      wr(addrs[i], 0);
    end
    wr(8'h14, 32'h0);
    rd(8'h14, d);
    check("R12 mask write ignored", d, IMPL);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d);
    check("R12 status write ignored", d, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d);
    check("R12 input write ignored", d, 32'h0);
    rd(8'h30, d);
    check("R4 unmapped reads zero", d, 32'h0);
    @(negedge clk);
    check("R4 no response without read", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic t_input();
    logic [31:0] d;
    pin_in = 24'h12_3456;
    settle();
    rd(8'h10, d);
    check("R3 input value", d, 32'h0012_3456);
    pin_in = '0;
    settle();
    rd(8'h20, d);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(8'h18, 32'h0000_000F);
    rd(8'h14, d);
    check("R5 unmask clears", d, 32'h00FF_FFF0);
    wr(8'h1C, 32'h0000_0005);
    rd(8'h14, d);
    check("R5 mask sets", d, 32'h00FF_FFF5);
    wr(8'h18, 32'h0);
    rd(8'h14, d);
    check("R5 zero write keeps", d, 32'h00FF_FFF5);
    wr(8'h1C, 32'hFFFF_FFFF);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    wr(8'h28, 32'h0000_0005);
    wr(8'h2C, 32'h0000_0004);
    rd(8'h20, d);
    check("R10 status clear before edges", d, 32'h0);
    pin_in = 24'h7;
    settle();
    rd(8'h20, d);
    check("R7 R8 rising latched", d, 32'h0000_0005);
    rd(8'h20, d);
    check("R10 cleared on read", d, 32'h0);
    wr(8'h18, 32'h0000_0002);
    check("R11 irq low no status", {31'b0, irq}, 32'h0);
    pin_in = 24'h0;
    settle();
    check("R11 irq high on unmasked", {31'b0, irq}, 32'h1);
    rd(8'h20, d);
    check("R7 R8 falling latched", d, 32'h0000_0006);
    @(negedge clk);
    check("R11 irq low after clear", {31'b0, irq}, 32'h0);
    wr(8'h1C, 32'h0000_0002);
    wr(8'h28, 0); wr(8'h2C, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(8'h24, 32'h0000_0018);
    wr(8'h28, 32'h0000_0008);
    @(negedge clk);
    rd(8'h20, d);
    check("R9 low level active", d, 32'h0000_0010);
    rd(8'h20, d);
    check("R9 level not cleared by read", d, 32'h0000_0010);
    wr(8'h18, 32'h0000_0008);
    check("R11 masked level quiet", {31'b0, irq}, 32'h0);
    pin_in = 24'h18;
    settle();
    rd(8'h20, d);
    check("R9 high level follows pin", d, 32'h0000_0008);
    check("R11 level irq", {31'b0, irq}, 32'h1);
    pin_in = 24'h0;
    settle();
    check("R11 level irq drops", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pads();
        t_readback();
        t_input();
        t_mask();
        t_edges();
        t_level();
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule